// File: doc/BRIEF.md
# Real-mode segment address generator

This block turns a 16-bit offset into a 20-bit physical address the way a segmented 16-bit processor does. It keeps four 16-bit segment bases (code, data, stack, extra). For each access it takes the base, moves it up by four bit positions and adds the offset. The whole address space is therefore 1 MB. Every segment starts on a 16-byte boundary and spans at most 64 KB, and different segments may overlap or coincide.

The segment used for an access is chosen by the kind of access. Instruction fetches go to the code base, plain data to the data base, stack traffic to the stack base, and string-destination writes to the extra base. A data access may name another segment through an override input. Software loads the bases through a small write port. The generated address appears on a registered output together with a valid strobe, one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: When `req_valid` is high at a rising edge, `addr_valid` is high after that edge and `addr_out` equals (base << 4) + offset, truncated to 20 bits, where base is the selected segment register.
- R2: An instruction fetch (`req_kind` = 2'b00) always uses the code segment, whatever `ovr_en` and `ovr_sel` hold.
- R3: A data access (`req_kind` = 2'b01) uses the data segment when `ovr_en` is low, and the segment named by `ovr_sel` when `ovr_en` is high.
- R4: A stack access (`req_kind` = 2'b10) uses the stack segment and a string-destination access (`req_kind` = 2'b11) uses the extra segment, and the override inputs have no effect on either.
- R5: Segment selects on `wr_sel` and `ovr_sel` use the codes 2'b00 code, 2'b01 data, 2'b10 stack, 2'b11 extra.
- R6: A carry out of address bit 19 is dropped, so addresses wrap modulo 1 MB (base 16'hFFFF with offset 16'h0010 gives 20'h00000).
- R7: A write on the segment port is used by requests issued in later cycles. A request issued in the same cycle as the write still uses the previous base.
- R8: Reset clears all four segment registers to zero and drives `addr_valid` and `addr_out` to zero.
- R9: In a cycle that follows an edge without a request, `addr_valid` is low and `addr_out` keeps its previous value.
- R10: The low four bits of every produced address equal the low four bits of the offset of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load a segment register this cycle |
| wr_sel | input | 2 | Segment register to load |
| wr_data | input | 16 | New segment base |
| req_valid | input | 1 | Address request present |
| req_kind | input | 2 | Access kind: fetch, data, stack, string destination |
| req_off | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Replace the default segment of a data access |
| ovr_sel | input | 2 | Segment used when the override is active |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | `addr_out` holds a new address this cycle |

## Verification
A wrong base in one of the segment registers stays hidden until a request selects that register. The next cycle then shows an address off by a multiple of 16, while the low nibble is still correct. For that reason every access kind is checked after each kind of base load, and overlapping segments are checked as well. A fault in the selection logic shows only for certain combinations of kind and override, so the bench sets the override on each kind of access. A fault in the write timing shows as the old or the new base appearing one cycle too early or too late, and the back-to-back write and access cases bring it out in that cycle.

// File: rtl/seg_addr_pkg.sv
`timescale 1ns/1ps
package seg_addr_pkg;

   // access kinds carried on req_kind
   typedef enum logic [1:0] {
      ACC_FETCH  = 2'b00,
      ACC_DATA   = 2'b01,
      ACC_STACK  = 2'b10,
      ACC_STRDST = 2'b11
   } acc_kind_e;

   // segment register identifiers on wr_sel / ovr_sel
   typedef enum logic [1:0] {
      SR_CODE  = 2'b00,
      SR_DATA  = 2'b01,
      SR_STACK = 2'b10,
      SR_EXTRA = 2'b11
   } seg_id_e;

   localparam int NUM_SEGS = 4;

endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile #(
   parameter int SEG_W  = 16,
   parameter int N_REGS = 4,
   localparam int SEL_W = $clog2(N_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [SEG_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [SEG_W-1:0] rd_val
);

   if (N_REGS < 2) begin : g_bad_count
      $error("seg_regfile: N_REGS must be at least 2");
   end

   logic [SEG_W-1:0] base_q [N_REGS];

   // R8: every base clears on reset; R7: a load lands at the edge
   for (genvar i = 0; i < N_REGS; i++) begin : g_base
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[i] <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(i))) begin
            base_q[i] <= wr_data;
         end
      end
   end

   assign rd_val = base_q[rd_sel];

endmodule

// File: rtl/seg_select.sv
`timescale 1ns/1ps
module seg_select
   import seg_addr_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       ovr_en,
   input  logic [1:0] ovr_sel,
   output logic [1:0] sel
);

   // R2, R3, R4: the override applies to plain data accesses only
   always_comb begin
      case (kind)
         ACC_FETCH:  sel = SR_CODE;
         ACC_DATA:   sel = ovr_en ? ovr_sel : SR_DATA;
         ACC_STACK:  sel = SR_STACK;
         default:    sel = SR_EXTRA;
      endcase
   end

endmodule

// File: rtl/seg_addr_adder.sv
`timescale 1ns/1ps
module seg_addr_adder #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   localparam int ADDR_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);

   if (SHIFT < 1) begin : g_bad_shift
      $error("seg_addr_adder: SHIFT must be positive");
   end
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("seg_addr_adder: offset wider than the address");
   end

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] off_ext;

   assign base = {seg, {SHIFT{1'b0}}};

   if (OFF_W == ADDR_W) begin : g_off_full
      assign off_ext = off;
   end else begin : g_off_pad
      assign off_ext = {{(ADDR_W - OFF_W){1'b0}}, off};
   end

   // R6: the sum stays at ADDR_W bits, so the top carry is lost
   assign addr = base + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   localparam int ADDR_W = SEG_W + SHIFT,
   localparam int SEL_W  = $clog2(seg_addr_pkg::NUM_SEGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [SEG_W-1:0]  wr_data,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              ovr_en,
   input  logic [SEL_W-1:0]  ovr_sel,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_valid
);

   if (SEL_W != 2) begin : g_bad_sel
      $error("seg_addr_gen: segment select must be two bits");
   end

   logic [SEL_W-1:0]  cur_sel;
   logic [SEG_W-1:0]  cur_base;
   logic [ADDR_W-1:0] sum_addr;
   logic [ADDR_W-1:0] addr_q;
   logic              vld_q;

   seg_regfile #(
      .SEG_W  (SEG_W),
      .N_REGS (seg_addr_pkg::NUM_SEGS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (cur_sel),
      .rd_val  (cur_base)
   );

   seg_select u_sel (
      .kind    (req_kind),
      .ovr_en  (ovr_en),
      .ovr_sel (ovr_sel),
      .sel     (cur_sel)
   );

   seg_addr_adder #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .SHIFT (SHIFT)
   ) u_add (
      .seg  (cur_base),
      .off  (req_off),
      .addr (sum_addr)
   );

   // R1, R8, R9: registered result, held while idle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            addr_q <= sum_addr;
         end
      end
   end

   assign addr_out   = addr_q;
   assign addr_valid = vld_q;

endmodule

// File: rtl/seg_addr_gen_chk.sv
`timescale 1ns/1ps
module seg_addr_gen_chk #(
   parameter int OFF_W  = 16,
   parameter int ADDR_W = 20,
   parameter int SHIFT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [OFF_W-1:0]  req_off,
   input logic [ADDR_W-1:0] addr_out,
   input logic              addr_valid
);

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);

   // R9
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(addr_out));

   // R10
   nibble_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (addr_out[SHIFT-1:0] == $past(req_off[SHIFT-1:0])));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
   .OFF_W  (OFF_W),
   .ADDR_W (ADDR_W),
   .SHIFT  (SHIFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_off    (req_off),
   .addr_out   (addr_out),
   .addr_valid (addr_valid)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [15:0] wr_data;
   logic        req_valid;
   logic [1:0]  req_kind;
   logic [15:0] req_off;
   logic        ovr_en;
   logic [1:0]  ovr_sel;
   logic [19:0] addr_out;
   logic        addr_valid;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [15:0] m_seg [4];
   logic [19:0] last_addr;

   always #4 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .req_valid  (req_valid),
      .req_kind   (req_kind),
      .req_off    (req_off),
      .ovr_en     (ovr_en),
      .ovr_sel    (ovr_sel),
      .addr_out   (addr_out),
      .addr_valid (addr_valid)
   );

   // expected address from the requirements: kinds 00 fetch, 01 data,
   // 10 stack, 11 string dest; segments 00 code, 01 data, 10 stack, 11 extra
   function automatic logic [19:0] exp_addr(input logic [1:0] k, input logic oe,
                                            input logic [1:0] os, input logic [15:0] off);
      logic [1:0]  s;
      logic [20:0] sum;
      case (k)
         2'b00:   s = 2'b00;
         2'b01:   s = oe ? os : 2'b01;
         2'b10:   s = 2'b10;
         default: s = 2'b11;
      endcase
      sum = {1'b0, m_seg[s], 4'h0} + {5'h0, off};
      return sum[19:0];
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one cycle at a falling edge, check after the next rising edge
   task automatic step(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                       input logic rv, input logic [1:0] rk, input logic [15:0] ro,
                       input logic oe, input logic [1:0] os, input string tag);
      logic [19:0] e;
      wr_en = we; wr_sel = ws; wr_data = wd;
      req_valid = rv; req_kind = rk; req_off = ro;
      ovr_en = oe; ovr_sel = os;
      e = rv ? exp_addr(rk, oe, os, ro) : last_addr;
      @(posedge clk);
      if (we) m_seg[ws] = wd;
      @(negedge clk);
      check(addr_valid === rv, {tag, " valid"}, {19'h0, addr_valid}, {19'h0, rv});
      check(addr_out === e, {tag, " addr"}, addr_out, e);
      last_addr = e;
   endtask

   task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
      step(1'b1, ws, wd, 1'b0, 2'b00, 16'h0, 1'b0, 2'b00, "R7 load");
   endtask

   initial begin
      #1_600_000;
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0;
      wr_en = 0; wr_sel = 0; wr_data = 0;
      req_valid = 0; req_kind = 0; req_off = 0; ovr_en = 0; ovr_sel = 0;
      for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
      last_addr = 20'h0;
      repeat (3) @(negedge clk);
      // R8: outputs cleared while in reset
      check(addr_valid === 1'b0, "R8 reset valid", {19'h0, addr_valid}, 20'h0);
      check(addr_out === 20'h0, "R8 reset addr", addr_out, 20'h0);
      rst_n = 1'b1;

      // R8: all bases read zero after reset
      step(0, 0, 0, 1, 2'b00, 16'h1234, 0, 0, "R8 code zero");
      step(0, 0, 0, 1, 2'b01, 16'h00A5, 0, 0, "R8 data zero");
      step(0, 0, 0, 1, 2'b10, 16'hFFFF, 0, 0, "R8 stack zero");
      step(0, 0, 0, 1, 2'b11, 16'h8001, 0, 0, "R8 extra zero");

      // R6: wrap past 1 MB
      wr(2'b00, 16'hFFFF);
      step(0, 0, 0, 1, 2'b00, 16'h0010, 0, 0, "R6 wrap zero");
      step(0, 0, 0, 1, 2'b00, 16'h000F, 0, 0, "R6 top address");
      step(0, 0, 0, 1, 2'b00, 16'hFFFF, 0, 0, "R6 wrap high");

      // R4/R5: overlapping data and extra segments
      wr(2'b01, 16'h1000);
      wr(2'b11, 16'h1001);
      step(0, 0, 0, 1, 2'b01, 16'h0010, 0, 0, "R3 data default");
      step(0, 0, 0, 1, 2'b11, 16'h0000, 0, 0, "R4 string extra");
      wr(2'b10, 16'hABCD);
      step(0, 0, 0, 1, 2'b10, 16'h1234, 0, 0, "R4 stack default");

      // R2: override ignored on fetch
      step(0, 0, 0, 1, 2'b00, 16'h0000, 1, 2'b01, "R2 fetch ovr");
      step(0, 0, 0, 1, 2'b00, 16'h0007, 1, 2'b10, "R2 fetch ovr stack");
      // R3, R5: override on data
      step(0, 0, 0, 1, 2'b01, 16'h0004, 1, 2'b10, "R3 ovr stack");
      step(0, 0, 0, 1, 2'b01, 16'h0020, 1, 2'b00, "R3 ovr code wrap");
      step(0, 0, 0, 1, 2'b01, 16'h0003, 1, 2'b11, "R5 ovr extra");
      // R4: override ignored on stack and string destination
      step(0, 0, 0, 1, 2'b10, 16'h0000, 1, 2'b01, "R4 stack ovr");
      step(0, 0, 0, 1, 2'b11, 16'h0010, 1, 2'b00, "R4 string ovr");

      // R7: same-cycle write uses old base, next cycle the new one
      step(1, 2'b01, 16'h2000, 1, 2'b01, 16'h0005, 0, 0, "R7 same cycle");
      step(0, 0, 0, 1, 2'b01, 16'h0005, 0, 0, "R7 next cycle");

      // R9: idle cycles hold the address
      step(0, 0, 0, 0, 2'b01, 16'h7777, 0, 0, "R9 idle");
      step(1, 2'b01, 16'h3333, 0, 2'b01, 16'h1111, 1, 2'b10, "R9 idle load");

      // R1, R10: random mix
      for (int n = 0; n < 600; n++) begin
         logic [15:0] off;
         logic        we;
         off = 16'($urandom);
         if ($urandom_range(0, 7) == 0) off = 16'hFFFF;
         if ($urandom_range(0, 7) == 0) off = 16'h0000;
         we = ($urandom_range(0, 3) == 0);
         step(we, 2'($urandom), ($urandom_range(0, 5) == 0) ? 16'hFFFF : 16'($urandom),
              ($urandom_range(0, 4) != 0), 2'($urandom), off,
              1'($urandom), 2'($urandom), "R1 random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule